// File: doc/BRIEF.md
# I2C Target Memory-Access Framer

This block lets an I2C controller read and write a wide internal address space. It listens on SCL and SDA through a synchroniser and picks out start and stop conditions. It then takes bytes in after a device-address byte that matches its own address. The first three payload bytes form a prefix and a 22-bit address. The top two bits of the first byte choose the access: a write, or the setup for a later read.

Write data follows the address directly, one memory write strobe per byte. A read needs the address setup first. The controller then sends a repeated start with the read bit, and the target returns data bytes until the controller declines one.

The address advances by one for every data byte, in either direction. SDA is modelled as an open-drain pad: a constant low drive value and an output enable. Every SCL phase must last at least six clock cycles.

Top module: `i2c_mem_target`

## Requirements
- R1: SCL and SDA pass through a two-flop synchroniser. A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A byte clocked without a preceding start is not acknowledged.
- R2: After a start, the target acknowledges the first byte only when bits 7:1 equal DEV_ADDR (default 7'h2A). Acknowledging means pulling SDA low during the ninth clock. On a mismatch it drives nothing until the next start.
- R3: In the first payload byte, bits 7:6 = 2'b10 select a write and 2'b00 selects a read setup. Bits 5:0 are address bits 21:16. The second and third payload bytes are address bits 15:8 and 7:0. A prefix of 2'b01 or 2'b11 is not acknowledged, and the frame is ignored until the next start.
- R4: In a write, each byte after the third address byte is acknowledged. Each such byte gives one single-cycle mem_wr pulse with mem_addr and mem_wdata. This continues until stop.
- R5: The address increases by one after each data byte written or read, and wraps from 0x3FFFFF to 0.
- R6: After a read setup and a repeated start with the device address plus read bit (bit 0 = 1), the target sends bytes MSB first. There is no dummy byte. The first byte comes from the setup address. mem_rdata is taken one cycle after mem_rd.
- R7: A NACK from the controller after a read byte ends the data phase. SDA is released, no further mem_rd is issued, and the target waits for a start or stop.
- R8: A read-bit address phase without a valid read setup returns 0xFF bytes and issues no mem_rd. A setup is invalid if none has occurred since the last stop, or if the last setup was a write.
- R9: Bytes that follow a completed read setup before the repeated start are not acknowledged. The setup stays valid for the next read.
- R10: After reset, sda_oe, mem_wr and mem_rd are low. The SDA drive only begins while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input |
| sda_o | output | 1 | SDA pad drive value, always 0 |
| sda_oe | output | 1 | SDA pad output enable (1 pulls the line low) |
| mem_addr | output | ADDR_W | Memory address for the current strobe |
| mem_wr | output | 1 | One-cycle memory write strobe |
| mem_wdata | output | 8 | Write data byte |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |

## Verification
A pin change is seen by the logic about three cycles later: two synchroniser flops plus the edge-detect flop.

- A write strobe follows one cycle after the eighth synchronised SCL rise.
- A read strobe follows one cycle after the address byte or the controller's ACK.
- Read data is captured one cycle later again.
- SDA drive changes one cycle after a synchronised SCL fall.

The bench holds every SCL phase for eight cycles and samples SDA four cycles into the high phase, well past these delays. It compares every strobe at each falling clock edge against queues of expected addresses and data. This fixes the order and content of strobes without tying the check to a single cycle.

// File: rtl/i2c_mt_pkg.sv
package i2c_mt_pkg;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_RX,
        LK_ACK_SETUP,
        LK_ACK_HOLD,
        LK_TX,
        LK_MACK
    } link_state_e;

    typedef enum logic [3:0] {
        FR_IDLE,
        FR_DEV,
        FR_HI,
        FR_MID,
        FR_LO,
        FR_WDATA,
        FR_RSET,
        FR_RDATA,
        FR_IGNORE
    } frame_state_e;

    localparam logic [1:0] KIND_READ  = 2'b00;
    localparam logic [1:0] KIND_WRITE = 2'b10;

endpackage

// File: rtl/i2c_mt_sync.sv
module i2c_mt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t q, d;
    logic  scl_s;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[STAGES-1];
        d.sda_prev = q.sda_pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    // Line conditions: SCL edges, and SDA edges while SCL stays high.
    assign scl_s    = q.scl_pipe[STAGES-1];
    assign sda_s    = q.sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~q.scl_prev;
    assign scl_fall = ~scl_s & q.scl_prev;
    assign start_p  = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
    assign stop_p   = scl_s & q.scl_prev & ~q.sda_prev & sda_s;

endmodule

// File: rtl/i2c_mt_link.sv
module i2c_mt_link
    import i2c_mt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_p,
    input  logic       stop_p,
    input  logic       ack_i,
    input  logic       tx_mode_i,
    input  logic [7:0] tx_byte_i,
    output logic       rx_done_o,
    output logic [7:0] rx_byte_o,
    output logic       mack_o,
    output logic       mnack_o,
    output logic       sda_oe_o
);

    typedef struct packed {
        link_state_e st;
        logic [3:0]  bitcnt;
        logic [7:0]  shift;
        logic        oe;
        logic        rx_done;
        logic        mack;
        logic        mnack;
    } link_t;

    link_t q, d;

    always_comb begin
        d         = q;
        d.rx_done = 1'b0;
        d.mack    = 1'b0;
        d.mnack   = 1'b0;
        if (start_p) begin
            d.st     = LK_RX;
            d.bitcnt = '0;
            d.oe     = 1'b0;
        end else if (stop_p) begin
            d.st = LK_IDLE;
            d.oe = 1'b0;
        end else begin
            unique case (q.st)
                LK_IDLE: ;
                LK_RX: begin
                    if (scl_rise) begin
                        d.shift  = {q.shift[6:0], sda_s};
                        d.bitcnt = q.bitcnt + 4'd1;
                        if (q.bitcnt == 4'd7) begin
                            d.rx_done = 1'b1;
                            d.st      = LK_ACK_SETUP;
                        end
                    end
                end
                LK_ACK_SETUP: begin
                    if (scl_fall) begin
                        if (ack_i) begin
                            d.oe = 1'b1;
                            d.st = LK_ACK_HOLD;
                        end else begin
                            d.st = LK_IDLE;
                        end
                    end
                end
                LK_ACK_HOLD: begin
                    if (scl_fall) begin
                        d.bitcnt = '0;
                        if (tx_mode_i) begin
                            d.shift = tx_byte_i;
                            d.oe    = ~tx_byte_i[7];
                            d.st    = LK_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = LK_RX;
                        end
                    end
                end
                LK_TX: begin
                    if (scl_rise) d.bitcnt = q.bitcnt + 4'd1;
                    if (scl_fall) begin
                        if (q.bitcnt == 4'd8) begin
                            d.oe = 1'b0;
                            d.st = LK_MACK;
                        end else begin
                            d.shift = {q.shift[6:0], 1'b0};
                            d.oe    = ~q.shift[6];
                        end
                    end
                end
                LK_MACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            d.mack = 1'b1;
                            d.st   = LK_ACK_HOLD;
                        end else begin
                            d.mnack = 1'b1;
                            d.st    = LK_IDLE;
                        end
                    end
                end
                default: d.st = LK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_done_o = q.rx_done;
    assign rx_byte_o = q.shift;
    assign mack_o    = q.mack;
    assign mnack_o   = q.mnack;
    assign sda_oe_o  = q.oe;

    // R10: the pad drive only begins right after a synchronised SCL fall
    a_r10_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> $past(scl_fall));

    // R7: after the controller declines a byte the line stays released
    a_r7_release_on_nack: assert property (@(posedge clk) disable iff (!rst_n)
        q.mnack |=> !q.oe);

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_mt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         ADDR_W      = 22,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_o,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    output logic              mem_rd,
    input  logic [7:0]        mem_rdata
);

    localparam int HI_W = ADDR_W - 16;

    logic       sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic       rx_done, mack, mnack;
    logic [7:0] rx_byte;

    typedef struct packed {
        frame_state_e      st;
        logic [ADDR_W-1:0] ptr;
        logic              is_write;
        logic              rd_ok;
        logic              ack;
        logic              tx_mode;
        logic [7:0]        tx_byte;
        logic              cap;
        logic              wr;
        logic              rd;
        logic [ADDR_W-1:0] maddr;
        logic [7:0]        wdata;
    } frame_t;

    frame_t q, d;
    logic   fetch;

    i2c_mt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    i2c_mt_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .ack_i     (q.ack),
        .tx_mode_i (q.tx_mode),
        .tx_byte_i (q.tx_byte),
        .rx_done_o (rx_done),
        .rx_byte_o (rx_byte),
        .mack_o    (mack),
        .mnack_o   (mnack),
        .sda_oe_o  (sda_oe)
    );

    always_comb begin
        d     = q;
        d.wr  = 1'b0;
        d.rd  = 1'b0;
        d.cap = q.rd;
        fetch = 1'b0;
        if (q.cap) d.tx_byte = mem_rdata;
        if (start_p) begin
            d.st      = FR_DEV;
            d.ack     = 1'b0;
            d.tx_mode = 1'b0;
        end else if (stop_p) begin
            d.st      = FR_IDLE;
            d.rd_ok   = 1'b0;
            d.ack     = 1'b0;
            d.tx_mode = 1'b0;
        end else begin
            unique case (q.st)
                FR_DEV: begin
                    if (rx_done) begin
                        if (rx_byte[7:1] == DEV_ADDR) begin
                            d.ack = 1'b1;
                            if (rx_byte[0]) begin
                                d.tx_mode = 1'b1;
                                d.st      = FR_RDATA;
                                fetch     = 1'b1;
                            end else begin
                                d.st = FR_HI;
                            end
                        end else begin
                            d.ack = 1'b0;
                            d.st  = FR_IGNORE;
                        end
                    end
                end
                FR_HI: begin
                    if (rx_done) begin
                        if (rx_byte[7:6] == KIND_WRITE || rx_byte[7:6] == KIND_READ) begin
                            d.ack                 = 1'b1;
                            d.is_write            = (rx_byte[7:6] == KIND_WRITE);
                            d.rd_ok               = 1'b0;
                            d.ptr[ADDR_W-1:16]    = rx_byte[HI_W-1:0];
                            d.st                  = FR_MID;
                        end else begin
                            d.ack = 1'b0;
                            d.st  = FR_IGNORE;
                        end
                    end
                end
                FR_MID: begin
                    if (rx_done) begin
                        d.ptr[15:8] = rx_byte;
                        d.ack       = 1'b1;
                        d.st        = FR_LO;
                    end
                end
                FR_LO: begin
                    if (rx_done) begin
                        d.ptr[7:0] = rx_byte;
                        d.ack      = 1'b1;
                        if (q.is_write) begin
                            d.st = FR_WDATA;
                        end else begin
                            d.rd_ok = 1'b1;
                            d.st    = FR_RSET;
                        end
                    end
                end
                FR_WDATA: begin
                    if (rx_done) begin
                        d.wr    = 1'b1;
                        d.maddr = q.ptr;
                        d.wdata = rx_byte;
                        d.ptr   = q.ptr + 1'b1;
                        d.ack   = 1'b1;
                    end
                end
                FR_RSET: begin
                    if (rx_done) begin
                        d.ack = 1'b0;
                        d.st  = FR_IGNORE;
                    end
                end
                FR_RDATA: begin
                    if (mack)  fetch = 1'b1;
                    if (mnack) d.st  = FR_IGNORE;
                end
                default: ;
            endcase
        end
        if (fetch) begin
            if (q.rd_ok) begin
                d.rd    = 1'b1;
                d.maddr = q.ptr;
                d.ptr   = q.ptr + 1'b1;
            end else begin
                d.tx_byte = 8'hFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_o     = 1'b0;
    assign mem_addr  = q.maddr;
    assign mem_wr    = q.wr;
    assign mem_wdata = q.wdata;
    assign mem_rd    = q.rd;

    // R4: a write strobe never lasts more than one cycle
    a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr |=> !q.wr);

    // R8: a read strobe needs a read setup that was valid the cycle before
    a_r8_rd_needs_setup: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd |-> $past(q.rd_ok));

    // R5: after every strobe the pointer sits one past the strobed address
    a_r5_pointer_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr || q.rd) |-> (q.ptr == ADDR_W'(q.maddr + 1'b1)));

    // R6: read strobes only occur while the target is transmitting
    a_r6_rd_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        q.rd |-> q.tx_mode);

endmodule

// File: tb/i2c_mem_target_test.sv
`timescale 1ns/1ps
module i2c_mem_target_test;

    localparam int Q = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_o, sda_oe, mem_wr, mem_rd;
    logic [21:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    wire         sda_line = m_sda & ~(sda_oe & ~sda_o);

    int checks = 0;
    int errors = 0;
    int oe_clocks = 0;
    logic oe_prev = 1'b0;
    bit   finished = 1'b0;

    logic [21:0] exp_waddr[$];
    logic [7:0]  exp_wdata[$];
    logic [21:0] exp_raddr[$];

    always #2 clk = ~clk;

    i2c_mem_target uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .sda_o     (sda_o),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rd    (mem_rd),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] pattern(input logic [21:0] a);
        return a[7:0] ^ a[15:8] ^ {a[21:16], 2'b01} ^ 8'h5A;
    endfunction

    // synchronous memory model: data appears the cycle after the strobe
    always @(posedge clk) if (mem_rd) mem_rdata <= pattern(mem_addr);

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-clock reference comparison of every strobe
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (sda_oe) oe_clocks++;
            if (sda_oe && !oe_prev) check(!scl, "R10", "drive began with SCL high", scl, 0);
            if (mem_wr) begin
                if (exp_waddr.size() == 0) check(1'b0, "R4", "unexpected write strobe", mem_addr, 0);
                else begin
                    check(mem_addr == exp_waddr[0], "R5", "write address", mem_addr, exp_waddr[0]);
                    check(mem_wdata == exp_wdata[0], "R4", "write data", mem_wdata, exp_wdata[0]);
                    void'(exp_waddr.pop_front());
                    void'(exp_wdata.pop_front());
                end
            end
            if (mem_rd) begin
                if (exp_raddr.size() == 0) check(1'b0, "R8", "unexpected read strobe", mem_addr, 0);
                else begin
                    check(mem_addr == exp_raddr[0], "R5", "read address", mem_addr, exp_raddr[0]);
                    void'(exp_raddr.pop_front());
                end
            end
        end
        oe_prev = sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start();
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(2*Q);
        m_sda = 1'b0; tick(2*Q); scl = 1'b0;
    endtask

    task automatic m_stop();
        tick(Q); m_sda = 1'b0; tick(Q); scl = 1'b1; tick(2*Q);
        m_sda = 1'b1; tick(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); m_sda = b[i]; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
        end
        tick(Q); m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        acked = !sda_line;
        tick(Q); scl = 1'b0;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(2*Q); scl = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl = 1'b0;
        end
        tick(Q); m_sda = give_ack ? 1'b0 : 1'b1; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0;
        tick(2); m_sda = 1'b1;
    endtask

    task automatic expect_ack(input logic [7:0] b, input bit want, input string req);
        bit a;
        send_byte(b, a);
        check(a == want, req, $sformatf("ack for byte %02h", b), a, want);
    endtask

    task automatic expect_rx(input bit give_ack, input logic [7:0] want, input string req);
        logic [7:0] b;
        recv_byte(give_ack, b);
        check(b == want, req, "read byte", b, want);
    endtask

    initial begin
        int oe0;
        tick(5);
        rst_n = 1'b1;
        tick(4);
        check(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);
        check(mem_wr == 1'b0 && mem_rd == 1'b0, "R10", "strobes after reset", {mem_wr, mem_rd}, 0);

        // R4 R5: write of three bytes across a byte-carry boundary
        exp_waddr.push_back(22'h1234FE); exp_wdata.push_back(8'hA1);
        exp_waddr.push_back(22'h1234FF); exp_wdata.push_back(8'hB2);
        exp_waddr.push_back(22'h123500); exp_wdata.push_back(8'hC3);
        m_start();
        expect_ack(8'h54, 1'b1, "R2");
        expect_ack(8'h92, 1'b1, "R3");
        expect_ack(8'h34, 1'b1, "R3");
        expect_ack(8'hFE, 1'b1, "R3");
        expect_ack(8'hA1, 1'b1, "R4");
        expect_ack(8'hB2, 1'b1, "R4");
        expect_ack(8'hC3, 1'b1, "R4");
        m_stop();
        check(exp_waddr.size() == 0, "R4", "writes outstanding", exp_waddr.size(), 0);

        // R2: another device address is left alone
        oe0 = oe_clocks;
        m_start();
        expect_ack(8'h56, 1'b0, "R2");
        expect_ack(8'h80, 1'b0, "R2");
        m_stop();
        check(oe_clocks == oe0, "R2", "drive cycles for foreign address", oe_clocks - oe0, 0);

        // R6 R5 R7: read with wrap at the top of the address space
        exp_raddr.push_back(22'h3FFFFE);
        exp_raddr.push_back(22'h3FFFFF);
        exp_raddr.push_back(22'h000000);
        m_start();
        expect_ack(8'h54, 1'b1, "R2");
        expect_ack(8'h3F, 1'b1, "R3");
        expect_ack(8'hFF, 1'b1, "R3");
        expect_ack(8'hFE, 1'b1, "R3");
        m_start();
        expect_ack(8'h55, 1'b1, "R6");
        expect_rx(1'b1, pattern(22'h3FFFFE), "R6");
        expect_rx(1'b1, pattern(22'h3FFFFF), "R5");
        expect_rx(1'b0, pattern(22'h000000), "R5");
        expect_rx(1'b0, 8'hFF, "R7");
        m_stop();
        check(exp_raddr.size() == 0, "R6", "reads outstanding", exp_raddr.size(), 0);

        // R9: extra byte after a read setup is refused, setup survives
        exp_raddr.push_back(22'h000010);
        m_start();
        expect_ack(8'h54, 1'b1, "R2");
        expect_ack(8'h00, 1'b1, "R3");
        expect_ack(8'h00, 1'b1, "R3");
        expect_ack(8'h10, 1'b1, "R3");
        expect_ack(8'h77, 1'b0, "R9");
        m_start();
        expect_ack(8'h55, 1'b1, "R9");
        expect_rx(1'b0, pattern(22'h000010), "R9");
        m_stop();
        check(exp_raddr.size() == 0, "R9", "reads outstanding", exp_raddr.size(), 0);

        // R8: read with no setup since the stop
        m_start();
        expect_ack(8'h55, 1'b1, "R8");
        expect_rx(1'b1, 8'hFF, "R8");
        expect_rx(1'b0, 8'hFF, "R8");
        m_stop();

        // R8: a write setup does not enable a read
        m_start();
        expect_ack(8'h54, 1'b1, "R2");
        expect_ack(8'h80, 1'b1, "R3");
        expect_ack(8'h00, 1'b1, "R3");
        expect_ack(8'h05, 1'b1, "R3");
        m_start();
        expect_ack(8'h55, 1'b1, "R8");
        expect_rx(1'b0, 8'hFF, "R8");
        m_stop();

        // R3: reserved prefixes are refused
        m_start();
        expect_ack(8'h54, 1'b1, "R2");
        expect_ack(8'h45, 1'b0, "R3");
        expect_ack(8'h00, 1'b0, "R3");
        m_stop();
        m_start();
        expect_ack(8'h54, 1'b1, "R2");
        expect_ack(8'hC0, 1'b0, "R3");
        m_stop();

        // R1: a byte without a start is not acknowledged
        tick(Q); scl = 1'b0;
        expect_ack(8'h54, 1'b0, "R1");
        m_stop();
        check(exp_waddr.size() == 0 && exp_raddr.size() == 0, "R1", "strobes outstanding",
              exp_waddr.size() + exp_raddr.size(), 0);

        tick(10);
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule